// File: doc/BRIEF.md
# Dual-Channel Fan Tachometer Capture Timer

This block measures how fast two fans spin by timing the gap between pulse edges on two tachometer inputs. A programmable prescaler divides the bus clock into a timer tick. Each channel owns a 16-bit down-counter that decrements once per tick while that channel runs. When the chosen edge of a channel's input arrives, the counter value is copied into that channel's capture register and the counter restarts from all-ones. Software reads the captured value and converts it to a speed; the averaging and speed arithmetic are left to software.

A compare register per channel detects a fan that is missing or stalled. When the counter steps down onto the programmed compare value, a timeout flag is raised. A counter that steps past zero raises a wrap flag. There are six sticky flags in total. Software clears them by writing ones, and each flag has its own interrupt enable. Writing a one to a channel's capture clear bit also restarts that channel's counter, so one write both acknowledges a sample and re-arms the measurement. The register port is a plain single-cycle write strobe with a combinational read; there is no stream traffic and so no valid/ready handshake.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset the prescaler register reads 0x00FF, both counters read 0xFFFF, and the capture, compare, run, mode, pending and enable registers read 0. The input synchronizers reset to the high level.
- R2: While any channel runs, a tick occurs once every (prescaler + 1) clock cycles. A running counter decrements by one per tick.
- R3: Each input passes through a two-flop synchronizer. A selected edge arriving at the pin is captured on the third rising clock edge after it. The capture stores the counter value from just before that edge and sets pending bit ch (bit 0 for channel 0, bit 1 for channel 1).
- R4: In the cycle of a capture, the counter reloads to 0xFFFF.
- R5: Mode bit (2+ch) selects the capture edge for channel ch: 0 selects high-to-low, 1 selects low-to-high. The other edge captures nothing.
- R6: Mode bit ch enables the input of channel ch. While it is 0, edges on that input capture nothing.
- R7: Writing a 1 to clear bit ch (bit 0 or 1) restarts counter ch at 0xFFFF.
- R8: When compare-enable bit ch is set and a tick moves counter ch onto compare ch, pending bit (4+ch) is set.
- R9: When a tick moves counter ch from 0 to 0xFFFF, pending bit (2+ch) is set.
- R10: irq is high exactly when some pending bit and its matching enable bit are both 1.
- R11: Pending bits are sticky. Writing the clear register clears exactly the bits written as 1. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R12: While run bit ch is 0, counter ch holds its value and no capture occurs on channel ch.
- R13: Registers read back what was written. Word addresses: 0 prescaler, 1 run (bit ch), 2 mode, 3/4 counter 0/1 (a write loads the count), 5/6 capture 0/1, 7/8 compare 0/1, 9 compare enable (bit ch), 10 pending, 11 clear (reads 0), 12 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Word address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| fan_in | input | 2 | Tachometer inputs, bit ch for channel ch |
| irq | output | 1 | Interrupt request |

## Verification
A fault in the prescaler phase or in a counter first shows at the read port, in the cycle after the faulty update. The reference model compares every cycle, so a count off by one tick fails at once. A fault in the synchronizer depth or the edge selection shows as a capture landing one cycle early or late, which changes the captured value and the pending word. A fault in a flag or enable state shows on irq in the cycle after the event, and again when the pending register is read.

// File: rtl/tach_pkg.sv
`timescale 1ns/1ps
package tach_pkg;
  localparam int NCH    = 2;
  localparam int NFLAG  = 3 * NCH;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_PRESC = 4'd0;
  localparam logic [ADDR_W-1:0] A_RUN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT0  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CMPEN = 4'd9;
  localparam logic [ADDR_W-1:0] A_PEND  = 4'd10;
  localparam logic [ADDR_W-1:0] A_CLR   = 4'd11;
  localparam logic [ADDR_W-1:0] A_IEN   = 4'd12;
endpackage

// File: rtl/tach_prescaler.sv
`timescale 1ns/1ps
module tach_prescaler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pcnt;

  assign tick = active && (pcnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt <= '0;
    else if (!active) pcnt <= '0;
    else if (tick)    pcnt <= '0;
    else              pcnt <= pcnt + 1'b1;
  end

  // R2: a tick restarts the phase count
  p_tick_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pcnt == '0));
endmodule

// File: rtl/tach_edge_sync.sv
`timescale 1ns/1ps
module tach_edge_sync #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE_LVL;
      sync_q <= IDLE_LVL;
      prev_q <= IDLE_LVL;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
  assign fall = prev_q & ~sync_q;

  // R3: an edge indication lasts a single cycle
  p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tach_channel.sv
`timescale 1ns/1ps
module tach_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         capture,
  input  logic         rearm,
  input  logic [W-1:0] cmp_val,
  input  logic         cmp_en,
  output logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         wrap_evt,
  output logic         match_evt
);
  localparam logic [W-1:0] RELOAD = '1;

  logic [W-1:0] cnt_q, cap_q, cnt_dec;
  logic         step;

  assign cnt_dec   = cnt_q - 1'b1;
  assign step      = run && tick && !load && !capture && !rearm;
  assign wrap_evt  = step && (cnt_q == '0);
  assign match_evt = step && cmp_en && (cnt_dec == cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      cap_q <= '0;
    end else begin
      if (capture) cap_q <= cnt_q;
      if (load)         cnt_q <= load_val;
      else if (capture) cnt_q <= RELOAD;
      else if (rearm)   cnt_q <= RELOAD;
      else if (step)    cnt_q <= cnt_dec;
    end
  end

  assign count   = cnt_q;
  assign cap_val = cap_q;

  // R4: a capture restarts the counter
  p_capture_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !load) |=> (cnt_q == RELOAD));
  // R12: a stopped counter holds
  p_stopped_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load && !capture && !rearm) |=> $stable(cnt_q));
  // R2: one tick takes exactly one off the count
  p_step_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tach_capture_timer.sv
`timescale 1ns/1ps
module tach_capture_timer
  import tach_pkg::*;
#(
  parameter int          CNT_W     = 16,
  parameter int          PSC_W     = 8,
  parameter logic [7:0]  PSC_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    fan_in,
  output logic              irq
);
  localparam int MODE_W = 2 * NCH;

  logic [PSC_W-1:0]  presc_q;
  logic [NCH-1:0]    run_q;
  logic [MODE_W-1:0] mode_q;
  logic [CNT_W-1:0]  cmp_q [NCH];
  logic [NCH-1:0]    cmpen_q;
  logic [NFLAG-1:0]  pend_q, ien_q, clr_mask, set_mask;

  logic [CNT_W-1:0]  cnt_w [NCH];
  logic [CNT_W-1:0]  cap_w [NCH];
  logic [NCH-1:0]    cap_evt, wrap_evt, match_evt;
  logic              tick;

  assign clr_mask = (bus_wr && bus_addr == A_CLR) ? bus_wdata[NFLAG-1:0] : '0;
  assign set_mask = {match_evt, wrap_evt, cap_evt};

  tach_prescaler #(.W(PSC_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .active(|run_q),
    .limit (presc_q),
    .tick  (tick)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CNT_ADDR = A_CNT0 + ADDR_W'(ch);
    localparam logic [ADDR_W-1:0] CMP_ADDR = A_CMP0 + ADDR_W'(ch);
    logic rise, fall, edge_hit;

    tach_edge_sync u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (fan_in[ch]),
      .rise (rise),
      .fall (fall)
    );

    assign edge_hit    = mode_q[NCH+ch] ? rise : fall;
    assign cap_evt[ch] = run_q[ch] && mode_q[ch] && edge_hit;

    tach_channel #(.W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q[ch]),
      .tick     (tick),
      .load     (bus_wr && bus_addr == CNT_ADDR),
      .load_val (bus_wdata[CNT_W-1:0]),
      .capture  (cap_evt[ch]),
      .rearm    (clr_mask[ch]),
      .cmp_val  (cmp_q[ch]),
      .cmp_en   (cmpen_q[ch]),
      .count    (cnt_w[ch]),
      .cap_val  (cap_w[ch]),
      .wrap_evt (wrap_evt[ch]),
      .match_evt(match_evt[ch])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cmp_q[ch] <= '0;
      else if (bus_wr && bus_addr == CMP_ADDR) cmp_q[ch] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= PSC_RESET[PSC_W-1:0];
      run_q   <= '0;
      mode_q  <= '0;
      cmpen_q <= '0;
      ien_q   <= '0;
      pend_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | set_mask;
      if (bus_wr) begin
        unique case (bus_addr)
          A_PRESC: presc_q <= bus_wdata[PSC_W-1:0];
          A_RUN:   run_q   <= bus_wdata[NCH-1:0];
          A_MODE:  mode_q  <= bus_wdata[MODE_W-1:0];
          A_CMPEN: cmpen_q <= bus_wdata[NCH-1:0];
          A_IEN:   ien_q   <= bus_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PRESC:      bus_rdata[PSC_W-1:0]  = presc_q;
      A_RUN:        bus_rdata[NCH-1:0]    = run_q;
      A_MODE:       bus_rdata[MODE_W-1:0] = mode_q;
      A_CNT0:       bus_rdata[CNT_W-1:0]  = cnt_w[0];
      A_CNT0 + 4'd1: bus_rdata[CNT_W-1:0] = cnt_w[1];
      A_CAP0:       bus_rdata[CNT_W-1:0]  = cap_w[0];
      A_CAP0 + 4'd1: bus_rdata[CNT_W-1:0] = cap_w[1];
      A_CMP0:       bus_rdata[CNT_W-1:0]  = cmp_q[0];
      A_CMP0 + 4'd1: bus_rdata[CNT_W-1:0] = cmp_q[1];
      A_CMPEN:      bus_rdata[NCH-1:0]    = cmpen_q;
      A_PEND:       bus_rdata[NFLAG-1:0]  = pend_q;
      A_IEN:        bus_rdata[NFLAG-1:0]  = ien_q;
      default:      bus_rdata = '0;
    endcase
  end

  assign irq = |(pend_q & ien_q);

  for (genvar f = 0; f < NFLAG; f++) begin : g_flag_chk
    // R11: a pending bit stays set until a clear names it
    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[f] && !clr_mask[f]) |=> pend_q[f]);
    // R11: a set event always lands, even against a clear
    p_flag_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      set_mask[f] |=> pend_q[f]);
  end
endmodule

// File: tb/tach_capture_timer_tb.sv
`timescale 1ns/1ps
module tach_capture_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  fan_in = 2'b11;
  logic        irq;
  logic        done = 1'b0;
  int          n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  tach_capture_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fan_in(fan_in), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  int          m_presc, m_pc, m_run, m_mode, m_cmpen, m_pend, m_ien;
  int          m_cnt [2], m_cap [2], m_cmp [2];
  bit          m_s1 [2], m_s2 [2], m_s3 [2];
  int          t_clr, t_set, t_old;
  bit          t_tick, t_rise, t_fall, t_cap;

  function automatic int m_read(int a);
    case (a)
      0: return m_presc;
      1: return m_run;
      2: return m_mode;
      3: return m_cnt[0];
      4: return m_cnt[1];
      5: return m_cap[0];
      6: return m_cap[1];
      7: return m_cmp[0];
      8: return m_cmp[1];
      9: return m_cmpen;
      10: return m_pend;
      12: return m_ien;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_presc = 255; m_pc = 0; m_run = 0; m_mode = 0; m_cmpen = 0;
      m_pend = 0; m_ien = 0;
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 65535; m_cap[c] = 0; m_cmp[c] = 0;
        m_s1[c] = 1; m_s2[c] = 1; m_s3[c] = 1;
      end
    end else begin
      t_tick = (m_run != 0) && (m_pc >= m_presc);
      t_clr  = (bus_wr && bus_addr == 11) ? (bus_wdata & 63) : 0;
      t_set  = 0;
      for (int c = 0; c < 2; c++) begin
        t_rise = !m_s3[c] && m_s2[c];
        t_fall = m_s3[c] && !m_s2[c];
        t_cap  = m_run[c] && m_mode[c] && (m_mode[2+c] ? t_rise : t_fall);
        t_old  = m_cnt[c];
        if (t_cap) begin m_cap[c] = t_old; t_set |= (1 << c); end
        if (bus_wr && bus_addr == 3 + c) m_cnt[c] = bus_wdata;
        else if (t_cap || t_clr[c])      m_cnt[c] = 65535;
        else if (m_run[c] && t_tick) begin
          m_cnt[c] = (t_old + 65535) % 65536;
          if (t_old == 0) t_set |= (1 << (2 + c));
          if (m_cmpen[c] && m_cnt[c] == m_cmp[c]) t_set |= (1 << (4 + c));
        end
      end
      m_pend = (m_pend & ~t_clr) | t_set;
      if (m_run == 0 || t_tick) m_pc = 0; else m_pc = m_pc + 1;
      if (bus_wr) begin
        case (bus_addr)
          0: m_presc = bus_wdata & 255;
          1: m_run   = bus_wdata & 3;
          2: m_mode  = bus_wdata & 15;
          7: m_cmp[0] = bus_wdata;
          8: m_cmp[1] = bus_wdata;
          9: m_cmpen = bus_wdata & 3;
          12: m_ien  = bus_wdata & 63;
          default: ;
        endcase
      end
      for (int c = 0; c < 2; c++) begin
        m_s3[c] = m_s2[c]; m_s2[c] = m_s1[c]; m_s1[c] = fan_in[c];
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 model irq", int'(irq), int'((m_pend & m_ien) != 0));
      check("R13 model readback", int'(bus_rdata), m_read(int'(bus_addr)));
    end
  end

  // ---------------- bus helpers ----------------
  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(posedge clk); #1;
    bus_addr = 4'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    int v1, v2;
    #11 rst_n = 1'b1;

    // R1: reset state
    rd(0, v1);  check("R1 prescaler reset", v1, 16'h00FF);
    rd(3, v1);  check("R1 counter0 reset", v1, 16'hFFFF);
    rd(4, v1);  check("R1 counter1 reset", v1, 16'hFFFF);
    rd(10, v1); check("R1 pending reset", v1, 0);
    check("R1 irq reset", int'(irq), 0);

    // R13: counter write while stopped
    wr(3, 1000);
    rd(3, v1); check("R13 counter load", v1, 1000);
    wr(7, 16'h1234);
    rd(7, v1); check("R13 compare readback", v1, 16'h1234);

    // R2: prescaler 0 -> one per cycle, prescaler 3 -> one per four
    wr(0, 0);
    wr(1, 1);
    rd(3, v1);
    repeat (5) @(negedge clk);
    v2 = int'(bus_rdata);
    check("R2 rate prescale 0", v2, v1 - 5);
    wr(0, 3);
    idle(2);
    rd(3, v1);
    repeat (8) @(negedge clk);
    v2 = int'(bus_rdata);
    check("R2 rate prescale 3", v2, v1 - 2);

    // R12: stopped counter holds
    wr(1, 0);
    rd(3, v1);
    repeat (10) @(negedge clk);
    v2 = int'(bus_rdata);
    check("R12 stopped hold", v2, v1);

    // R8, R9: timeout on reaching compare, wrap through zero
    wr(0, 0);
    wr(11, 16'h3F);
    wr(7, 2);
    wr(9, 1);
    wr(3, 5);
    wr(1, 1);
    idle(10);
    wr(1, 0);
    rd(10, v1);
    check("R8 timeout flag", v1 & 16'h10, 16'h10);
    check("R9 wrap flag", v1 & 16'h04, 16'h04);
    check("R3 no capture without edge", v1 & 16'h03, 0);
    check("R10 irq masked", int'(irq), 0);
    wr(12, 16'h10);
    @(negedge clk);
    check("R10 irq enabled", int'(irq), 1);
    wr(11, 16'h04);
    rd(10, v1); check("R11 selective clear", v1, 16'h10);
    wr(11, 16'h10);
    @(negedge clk);
    check("R10 irq after clear", int'(irq), 0);
    wr(12, 0);

    // R3, R4: falling-edge capture on channel 0
    wr(3, 16'h8000);
    wr(2, 1);
    wr(1, 1);
    fan_in[0] = 1'b0;
    idle(6);
    wr(1, 0);
    rd(10, v1); check("R3 capture flag", v1, 16'h01);
    rd(5, v1);  check("R3 captured value", v1, 16'h7FFE);
    rd(3, v1);  check("R4 counter restarted", int'(v1 > 16'hFFF0), 1);

    // R7: clearing the capture flag restarts the counter
    wr(11, 16'h01);
    rd(3, v1);  check("R7 reload on clear", v1, 16'hFFFF);
    rd(10, v1); check("R7 flag cleared", v1, 0);

    // R5: edge selection
    wr(1, 1);
    fan_in[0] = 1'b1;
    idle(6);
    wr(1, 0);
    rd(10, v1); check("R5 rising ignored in falling mode", v1, 0);
    wr(2, 16'h5);
    wr(1, 1);
    fan_in[0] = 1'b0;
    idle(6);
    rd(10, v1); check("R5 falling ignored in rising mode", v1, 0);
    fan_in[0] = 1'b1;
    idle(6);
    wr(1, 0);
    rd(10, v1); check("R5 rising captured", v1, 16'h01);
    wr(11, 16'h3F);

    // R6: input enable gating on channel 1
    wr(2, 16'h1);
    wr(1, 3);
    fan_in[1] = 1'b0;
    idle(6);
    fan_in[1] = 1'b1;
    idle(6);
    rd(10, v1); check("R6 disabled input ignored", v1 & 16'h02, 0);
    wr(2, 16'h3);
    fan_in[1] = 1'b0;
    idle(6);
    wr(1, 0);
    rd(10, v1); check("R6 enabled input captured", v1 & 16'h02, 16'h02);

    // R12: no capture while stopped
    wr(11, 16'h3F);
    fan_in[1] = 1'b1;
    idle(6);
    fan_in[1] = 1'b0;
    idle(6);
    rd(10, v1); check("R12 no capture while stopped", v1, 0);

    idle(4);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule